// File: doc/BRIEF.md
# Timer Core with Self-Clearing Software Event Register

This block is a four-channel 16-bit timer. Its counter counts up, down or centre-aligned against an auto-reload limit, and a prescaler sets how often it steps. Each channel holds one compare/capture value and works either as an output compare or as an input capture. Sticky status flags record update, trigger, per-channel and per-channel overcapture events. An interrupt request is raised when any enabled flag is set. Each event source can also issue a one-cycle DMA request pulse.

Software reaches the block through a simple synchronous register port. One write-only register lets software force events. A 1 in the update position restarts the counter. The restart value depends on the counting direction, and the prescaler restarts at the same time. A 1 in a channel position acts like a hardware channel event. In capture mode that event also latches the live count and can flag an overcapture. A 1 in the trigger position sets the trigger flag. The register takes no storage and reads back as zero.

Register word addresses: 0 control (bit 0 run, bits 2:1 mode: 0 up, 1 down, 2 or 3 centre-aligned), 1 interrupt enables, 2 DMA enables, 3 status, 4 event generation, 5 channel mode (bit i = 1 puts channel i in capture), 6 counter, 7 prescaler reload, 8 auto-reload, 9 to 12 channel values 0 to 3. The enable and status registers use the event layout: bit 0 update, bit 1+i channel i, bit 6 trigger. Status bits 9+i are the channel overcapture flags.

Top module: `tmr_core`

## Requirements
- R1: After reset, every register reads 0, and the interrupt and DMA request outputs are low.
- R2: The event register (address 4) always reads 0. Writing 0 to any of its bits changes no status flag and no counter value.
- R3: Writing 1 to event bit 0 in up or centre-aligned mode sets the counter to 0 and clears the prescaler count. It also sets status bit 0.
- R4: Writing 1 to event bit 0 in down mode loads the counter with the auto-reload value most recently written.
- R5: Written prescaler and auto-reload values are buffered. They become active only on an update event (forced, or a counter wrap). A write alone does not change the active limit.
- R6: Writing 1 to event bit 6 sets status bit 6.
- R7: Writing 1 to event bit 1+i with channel i in compare mode sets status bit 1+i. The channel value is left unchanged.
- R8: Writing 1 to event bit 1+i with channel i in capture mode latches the counter value held before the write into channel value i. It also sets status bit 1+i.
- R9: A forced capture on channel i while status bit 1+i is already set also sets overcapture status bit 9+i.
- R10: Status flags are sticky. A status write clears exactly the bits written as 0 and leaves the bits written as 1 unchanged.
- R11: The interrupt output is high one cycle after any status flag in bit positions 0 to 6 is set with its interrupt enable bit set.
- R12: Each event whose DMA enable bit is set gives a one-cycle pulse on dma_req in the clock after the event. The pulse order is: bit 0 update, bits 1 to 4 channels, bit 5 trigger.
- R13: Several event bits set in one write all take effect in the same clock edge. A capture sees the count from before the forced update.
- R14: While running, the counter wraps at the active auto-reload value and sets status bit 0. A channel in compare mode sets its flag when the count steps onto its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write word address |
| wr_data | input | 16 | Register write data |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | 4 | Register read word address |
| rd_data | output | 16 | Read data, valid the cycle after rd_en |
| irq | output | 1 | Interrupt request, registered |
| dma_req | output | 6 | Per-source DMA request pulses |

## Verification
The assertions assume that reset is held for at least two clock edges. They also assume that at most one register write occurs per cycle, so that a status clear and an event generate never collide. The stimulus uses single-word writes and reads, each spread over two cycles. It holds reset for several cycles and stops the counter before any test that needs an exact count. Counting is enabled only for a fixed two-cycle window or a long run whose outcome is a sticky flag, so results never depend on an unknown elapsed count.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int A_CTRL   = 0;
  localparam int A_IEN    = 1;
  localparam int A_DEN    = 2;
  localparam int A_STAT   = 3;
  localparam int A_EVG    = 4;
  localparam int A_CHMODE = 5;
  localparam int A_CNT    = 6;
  localparam int A_PSC    = 7;
  localparam int A_ARR    = 8;
  localparam int A_CCV0   = 9;

  typedef enum logic [1:0] {
    MODE_UP     = 2'd0,
    MODE_DOWN   = 2'd1,
    MODE_CENTER = 2'd2,
    MODE_CENT2  = 2'd3
  } cnt_mode_e;
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int PW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run,
  input  logic          clr,
  input  logic          load,
  input  logic [PW-1:0] div_buf,
  output logic          tick
);
  logic [PW-1:0] pcnt_q;
  logic [PW-1:0] div_q;

  assign tick = run && !clr && (pcnt_q == div_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      pcnt_q <= '0;
      div_q  <= '0;
    end else begin
      if (clr)
        pcnt_q <= '0;
      else if (run)
        pcnt_q <= (pcnt_q == div_q) ? '0 : pcnt_q + PW'(1);
      if (load)
        div_q <= div_buf;
    end
  end
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter
  import tmr_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          force_upd,
  input  logic          wr_cnt,
  input  logic [CW-1:0] wr_val,
  input  logic [CW-1:0] arr_buf,
  input  logic [1:0]    mode,
  output logic [CW-1:0] cnt,
  output logic          wrap,
  output logic          adv
);
  logic [CW-1:0] cnt_q, nxt, arr_act_q;
  logic          dir_dn_q, dn_nxt;

  always_comb begin
    nxt    = cnt_q;
    dn_nxt = dir_dn_q;
    wrap   = 1'b0;
    if (force_upd) begin
      nxt    = (mode == MODE_DOWN) ? arr_buf : '0;
      dn_nxt = 1'b0;
    end else if (wr_cnt) begin
      nxt = wr_val;
    end else if (tick) begin
      if (mode == MODE_UP) begin
        if (cnt_q >= arr_act_q) begin
          nxt  = '0;
          wrap = 1'b1;
        end else nxt = cnt_q + CW'(1);
      end else if (mode == MODE_DOWN) begin
        if (cnt_q == '0) begin
          nxt  = arr_act_q;
          wrap = 1'b1;
        end else nxt = cnt_q - CW'(1);
      end else if (!dir_dn_q) begin
        if (cnt_q >= arr_act_q) begin
          wrap = 1'b1;
          if (arr_act_q != '0) begin
            nxt    = arr_act_q - CW'(1);
            dn_nxt = 1'b1;
          end else nxt = '0;
        end else nxt = cnt_q + CW'(1);
      end else begin
        if (cnt_q == '0) begin
          wrap   = 1'b1;
          nxt    = (arr_act_q != '0) ? CW'(1) : '0;
          dn_nxt = 1'b0;
        end else nxt = cnt_q - CW'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q     <= '0;
      dir_dn_q  <= 1'b0;
      adv       <= 1'b0;
      arr_act_q <= '0;
    end else begin
      cnt_q    <= nxt;
      dir_dn_q <= dn_nxt;
      adv      <= tick && !force_upd && !wr_cnt;
      if (force_upd || wrap)
        arr_act_q <= arr_buf;
    end
  end

  assign cnt = cnt_q;
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cap_mode,
  input  logic          force_ev,
  input  logic          adv,
  input  logic [CW-1:0] cnt,
  input  logic          wr_ccv,
  input  logic [CW-1:0] wr_val,
  input  logic          clr_flag,
  input  logic          clr_ovc,
  output logic [CW-1:0] ccv,
  output logic          flag,
  output logic          ovc,
  output logic          evt
);
  logic hit, cap;

  assign hit = adv && !cap_mode && (cnt == ccv);
  assign cap = force_ev && cap_mode;
  assign evt = force_ev || hit;

  always_ff @(posedge clk) begin
    if (rst) begin
      ccv  <= '0;
      flag <= 1'b0;
      ovc  <= 1'b0;
    end else begin
      if (cap)
        ccv <= cnt;
      else if (wr_ccv && !cap_mode)
        ccv <= wr_val;
      if (evt)
        flag <= 1'b1;
      else if (clr_flag)
        flag <= 1'b0;
      if (cap && flag)
        ovc <= 1'b1;
      else if (clr_ovc)
        ovc <= 1'b0;
    end
  end
endmodule

// File: rtl/tmr_core.sv
module tmr_core
  import tmr_pkg::*;
#(
  parameter int CW  = 16,
  parameter int NCH = 4,
  parameter int DW  = 16,
  parameter int AW  = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_en,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data,
  output logic          irq,
  output logic [NCH+1:0] dma_req
);
  localparam int TRG_BIT = NCH + 2;
  localparam int OVC_LO  = NCH + 5;
  localparam logic [DW-1:0] SRC_MASK =
    DW'((1 << (NCH + 1)) - 1) | DW'(1 << TRG_BIT);

  logic [2:0]     ctrl_q;
  logic [DW-1:0]  ien_q, den_q;
  logic [NCH-1:0] chmode_q;
  logic [CW-1:0]  psc_buf_q, arr_buf_q;
  logic           upd_f_q, trg_f_q;
  logic [DW-1:0]  stat_vec;

  logic           evg_wr, stat_wr;
  logic           ev_upd, ev_trg;
  logic [NCH-1:0] ev_ch;

  logic           tick, wrap, adv, upd_evt;
  logic [CW-1:0]  cnt;

  logic [CW-1:0]  ccv [NCH];
  logic [NCH-1:0] ch_flag, ch_ovc, ch_evt;

  logic [DW-1:0]  rd_mux;

  assign evg_wr  = wr_en && (wr_addr == AW'(A_EVG));
  assign stat_wr = wr_en && (wr_addr == AW'(A_STAT));
  assign ev_upd  = evg_wr && wr_data[0];
  assign ev_trg  = evg_wr && wr_data[TRG_BIT];
  assign upd_evt = ev_upd || wrap;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q    <= '0;
      ien_q     <= '0;
      den_q     <= '0;
      chmode_q  <= '0;
      psc_buf_q <= '0;
      arr_buf_q <= '0;
    end else if (wr_en) begin
      if (wr_addr == AW'(A_CTRL))   ctrl_q    <= wr_data[2:0];
      if (wr_addr == AW'(A_IEN))    ien_q     <= wr_data & SRC_MASK;
      if (wr_addr == AW'(A_DEN))    den_q     <= wr_data & SRC_MASK;
      if (wr_addr == AW'(A_CHMODE)) chmode_q  <= wr_data[NCH-1:0];
      if (wr_addr == AW'(A_PSC))    psc_buf_q <= CW'(wr_data);
      if (wr_addr == AW'(A_ARR))    arr_buf_q <= CW'(wr_data);
    end
  end

  tmr_prescaler #(.PW(CW)) i_psc (
    .clk     (clk),
    .rst     (rst),
    .run     (ctrl_q[0]),
    .clr     (ev_upd),
    .load    (upd_evt),
    .div_buf (psc_buf_q),
    .tick    (tick)
  );

  tmr_counter #(.CW(CW)) i_cnt (
    .clk       (clk),
    .rst       (rst),
    .tick      (tick),
    .force_upd (ev_upd),
    .wr_cnt    (wr_en && (wr_addr == AW'(A_CNT))),
    .wr_val    (CW'(wr_data)),
    .arr_buf   (arr_buf_q),
    .mode      (ctrl_q[2:1]),
    .cnt       (cnt),
    .wrap      (wrap),
    .adv       (adv)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    assign ev_ch[g] = evg_wr && wr_data[g+1];
    tmr_channel #(.CW(CW)) i_ch (
      .clk      (clk),
      .rst      (rst),
      .cap_mode (chmode_q[g]),
      .force_ev (ev_ch[g]),
      .adv      (adv),
      .cnt      (cnt),
      .wr_ccv   (wr_en && (wr_addr == AW'(A_CCV0 + g))),
      .wr_val   (CW'(wr_data)),
      .clr_flag (stat_wr && !wr_data[g+1]),
      .clr_ovc  (stat_wr && !wr_data[OVC_LO+g]),
      .ccv      (ccv[g]),
      .flag     (ch_flag[g]),
      .ovc      (ch_ovc[g]),
      .evt      (ch_evt[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      upd_f_q <= 1'b0;
      trg_f_q <= 1'b0;
    end else begin
      if (upd_evt) upd_f_q <= 1'b1;
      else if (stat_wr && !wr_data[0]) upd_f_q <= 1'b0;
      if (ev_trg) trg_f_q <= 1'b1;
      else if (stat_wr && !wr_data[TRG_BIT]) trg_f_q <= 1'b0;
    end
  end

  always_comb begin
    stat_vec          = '0;
    stat_vec[0]       = upd_f_q;
    stat_vec[TRG_BIT] = trg_f_q;
    for (int i = 0; i < NCH; i++) begin
      stat_vec[i+1]      = ch_flag[i];
      stat_vec[OVC_LO+i] = ch_ovc[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq     <= 1'b0;
      dma_req <= '0;
    end else begin
      irq        <= |(stat_vec & ien_q);
      dma_req[0] <= upd_evt && den_q[0];
      for (int i = 0; i < NCH; i++)
        dma_req[i+1] <= ch_evt[i] && den_q[i+1];
      dma_req[NCH+1] <= ev_trg && den_q[TRG_BIT];
    end
  end

  always_comb begin
    rd_mux = '0;
    if (rd_addr == AW'(A_CTRL))   rd_mux = DW'(ctrl_q);
    if (rd_addr == AW'(A_IEN))    rd_mux = ien_q;
    if (rd_addr == AW'(A_DEN))    rd_mux = den_q;
    if (rd_addr == AW'(A_STAT))   rd_mux = stat_vec;
    if (rd_addr == AW'(A_CHMODE)) rd_mux = DW'(chmode_q);
    if (rd_addr == AW'(A_CNT))    rd_mux = DW'(cnt);
    if (rd_addr == AW'(A_PSC))    rd_mux = DW'(psc_buf_q);
    if (rd_addr == AW'(A_ARR))    rd_mux = DW'(arr_buf_q);
    for (int i = 0; i < NCH; i++)
      if (rd_addr == AW'(A_CCV0 + i)) rd_mux = DW'(ccv[i]);
  end

  always_ff @(posedge clk) begin
    if (rst)        rd_data <= '0;
    else if (rd_en) rd_data <= rd_mux;
  end
endmodule

// File: rtl/tmr_core_chk.sv
module tmr_core_chk
  import tmr_pkg::*;
#(
  parameter int CW  = 16,
  parameter int NCH = 4,
  parameter int DW  = 16,
  parameter int AW  = 4
) (
  input logic           clk,
  input logic           rst,
  input logic           wr_en,
  input logic [AW-1:0]  wr_addr,
  input logic [DW-1:0]  wr_data,
  input logic           rd_en,
  input logic [AW-1:0]  rd_addr,
  input logic [DW-1:0]  rd_data,
  input logic           irq,
  input logic [NCH+1:0] dma_req,
  input logic [CW-1:0]  cnt,
  input logic [1:0]     mode,
  input logic [CW-1:0]  arr_buf,
  input logic [DW-1:0]  stat_vec,
  input logic [DW-1:0]  ien,
  input logic [DW-1:0]  den,
  input logic [NCH-1:0] chmode
);
  localparam int TRG_BIT = NCH + 2;
  localparam int OVC_LO  = NCH + 5;

  logic evg_wr, stat_wr;
  assign evg_wr  = wr_en && (wr_addr == AW'(A_EVG));
  assign stat_wr = wr_en && (wr_addr == AW'(A_STAT));

  // R2
  evg_reads_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en && rd_addr == AW'(A_EVG)) |=> (rd_data == '0));

  // R3
  upd_clears_up_chk: assert property (@(posedge clk) disable iff (rst)
    (evg_wr && wr_data[0] && mode != MODE_DOWN) |=> (cnt == '0 && stat_vec[0]));

  // R4
  upd_loads_down_chk: assert property (@(posedge clk) disable iff (rst)
    (evg_wr && wr_data[0] && mode == MODE_DOWN) |=> (cnt == $past(arr_buf)));

  // R6
  trg_sets_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (evg_wr && wr_data[TRG_BIT]) |=> stat_vec[TRG_BIT]);

  // R9
  ovc_on_recapture_chk: assert property (@(posedge clk) disable iff (rst)
    (evg_wr && wr_data[1] && chmode[0] && stat_vec[1]) |=> stat_vec[OVC_LO]);

  // R10
  flag_only_sw_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(stat_vec[TRG_BIT]) |-> $past(stat_wr && !wr_data[TRG_BIT]));

  // R11
  irq_follows_flags_chk: assert property (@(posedge clk) disable iff (rst)
    irq == $past(|(stat_vec & ien)));

  // R12
  dma_needs_enable_chk: assert property (@(posedge clk) disable iff (rst)
    dma_req[NCH+1] |-> $past(den[TRG_BIT] && evg_wr && wr_data[TRG_BIT]));
endmodule

bind tmr_core tmr_core_chk #(.CW(CW), .NCH(NCH), .DW(DW), .AW(AW)) i_chk (
  .clk      (clk),
  .rst      (rst),
  .wr_en    (wr_en),
  .wr_addr  (wr_addr),
  .wr_data  (wr_data),
  .rd_en    (rd_en),
  .rd_addr  (rd_addr),
  .rd_data  (rd_data),
  .irq      (irq),
  .dma_req  (dma_req),
  .cnt      (cnt),
  .mode     (ctrl_q[2:1]),
  .arr_buf  (arr_buf_q),
  .stat_vec (stat_vec),
  .ien      (ien_q),
  .den      (den_q),
  .chmode   (chmode_q)
);

// File: tb/test_tmr_core.sv
`timescale 1ns/1ps
module test_tmr_core;
  localparam logic [3:0] CTRL = 4'd0, IEN = 4'd1, DEN = 4'd2, STAT = 4'd3,
                         EVG = 4'd4, CHM = 4'd5, CNT = 4'd6, PSC = 4'd7,
                         ARR = 4'd8, CCV0 = 4'd9, CCV1 = 4'd10, CCV2 = 4'd11,
                         CCV3 = 4'd12;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [3:0]  wr_addr = '0, rd_addr = '0;
  logic [15:0] wr_data = '0;
  logic [15:0] rd_data;
  logic        irq;
  logic [5:0]  dma_req;

  int checks = 0;
  int errors = 0;

  logic [15:0] exp_q[$];
  string       tag_q[$];
  logic        rd_q = 1'b0;

  always #10 clk = ~clk;

  tmr_core i_tmr_core (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq),
    .dma_req(dma_req)
  );

  task automatic chk(input bit ok, input string tag, input logic [15:0] got,
                     input logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s got %h exp %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, input logic [15:0] e, input string tag);
    exp_q.push_back(e);
    tag_q.push_back(tag);
    @(negedge clk);
    rd_en = 1'b1; rd_addr = a;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  always @(posedge clk) rd_q <= rd_en;

  always @(negedge clk) begin
    if (rd_q && exp_q.size() > 0) begin
      logic [15:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      chk(rd_data === e, t, rd_data, e);
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog got %h exp %h", 16'h0, 16'h1);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    chk(irq === 1'b0 && dma_req === '0, "R1 outputs", {9'd0, dma_req, irq}, 16'h0);
    rd(CTRL, 16'h0, "R1 ctrl");
    rd(STAT, 16'h0, "R1 stat");
    rd(CNT,  16'h0, "R1 cnt");

    wr(CNT, 16'h1234);
    wr(EVG, 16'h0000);
    rd(STAT, 16'h0, "R2 zero write no flag");
    rd(CNT, 16'h1234, "R2 zero write no count change");
    rd(EVG, 16'h0, "R2 reads zero");

    wr(ARR, 16'h00FF);
    wr(EVG, 16'h0001);
    rd(CNT, 16'h0, "R3 up cleared");
    rd(STAT, 16'h0001, "R3 update flag");
    rd(EVG, 16'h0, "R2 reads zero after event");

    wr(CTRL, 16'h0004);
    wr(CNT, 16'h0321);
    wr(EVG, 16'h0001);
    rd(CNT, 16'h0, "R3 center cleared");

    wr(ARR, 16'h0040);
    wr(CTRL, 16'h0002);
    wr(EVG, 16'h0001);
    rd(CNT, 16'h0040, "R4 down loads reload");
    wr(CNT, 16'h0000);
    wr(ARR, 16'h0022);
    wr(CTRL, 16'h0003);
    wr(CTRL, 16'h0002);
    rd(CNT, 16'h003F, "R5 active reload kept");

    wr(STAT, 16'h0000);
    wr(IEN, 16'h0040);
    wr(DEN, 16'h0040);
    wr(EVG, 16'h0040);
    chk(dma_req === 6'b100000, "R12 trigger pulse", {10'd0, dma_req}, 16'h0020);
    @(negedge clk);
    chk(irq === 1'b1, "R11 irq raised", {15'd0, irq}, 16'h1);
    chk(dma_req === 6'b0, "R12 single pulse", {10'd0, dma_req}, 16'h0);
    rd(STAT, 16'h0040, "R6 trigger flag");

    wr(STAT, 16'hFFFF);
    rd(STAT, 16'h0040, "R10 write ones keeps");
    wr(STAT, 16'hFFBF);
    rd(STAT, 16'h0000, "R10 write zero clears");
    @(negedge clk);
    chk(irq === 1'b0, "R11 irq dropped", {15'd0, irq}, 16'h0);

    wr(CCV0, 16'h0077);
    wr(EVG, 16'h0002);
    rd(STAT, 16'h0002, "R7 compare flag");
    rd(CCV0, 16'h0077, "R7 compare value kept");

    wr(STAT, 16'h0000);
    wr(CHM, 16'h0002);
    wr(CNT, 16'h0ABC);
    wr(EVG, 16'h0004);
    rd(CCV1, 16'h0ABC, "R8 captured");
    rd(STAT, 16'h0004, "R8 flag no overcapture");
    wr(CNT, 16'h0DEF);
    wr(EVG, 16'h0004);
    rd(CCV1, 16'h0DEF, "R9 recapture");
    rd(STAT, 16'h0404, "R9 overcapture");

    wr(STAT, 16'h0000);
    wr(CTRL, 16'h0000);
    wr(CHM, 16'h0003);
    wr(CNT, 16'h0055);
    wr(EVG, 16'h0043);
    rd(CCV0, 16'h0055, "R13 capture sees old count");
    rd(CNT, 16'h0000, "R13 update same edge");
    rd(STAT, 16'h0043, "R13 all flags");

    wr(CHM, 16'h0000);
    wr(CCV2, 16'h0003);
    wr(CCV3, 16'h001F);
    wr(ARR, 16'h0005);
    wr(EVG, 16'h0001);
    wr(STAT, 16'h0000);
    wr(CTRL, 16'h0001);
    repeat (20) @(negedge clk);
    wr(CTRL, 16'h0000);
    rd(STAT, 16'h0009, "R14 wrap and compare flags");

    repeat (4) @(negedge clk);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule